// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is a Mealy state machine that accepts at most one coin per clock and keeps a running credit in 5-cent units. On every coin it decides one of three things. It can keep the coin and add it to the credit. It can complete a sale of a single 40-cent product. Or it can refuse the coin because accepting it would push the credit past 50 cents.

Both outputs depend on the held credit and on the coin presented in the same cycle:
- a 2-bit returned-coin code;
- a one-bit dispense flag.

A sale pays out at most one change coin, either a nickel or a dime, and clears the credit. A refused coin is handed straight back with its own code, and the credit stays as it was. The held credit is also visible as a port, so the surrounding logic can display it.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the held credit to 0 cents (credit port value 0) at the next rising clock edge.
- R2: With coin code 00 (no coin), the return code is 00, dispense is 0, and the credit is the same after the clock edge.
- R3: Coin code 01 is worth 5 cents, code 10 is worth 10 cents and code 11 is worth 25 cents. The credit port counts in 5-cent units, so value 3 means 15 cents.
- R4: When credit plus coin is below 40 cents, return and dispense are both 0 and the new credit is the sum.
- R5: When credit plus coin is from 40 to 50 cents inclusive, dispense is 1 and the credit becomes 0 after the edge.
- R6: The change returned on a sale is the sum minus 40 cents, coded as 00 for none, 01 for 5 cents and 10 for 10 cents. It is never 11.
- R7: When credit plus coin exceeds 50 cents, the coin is refused: the return code equals the input coin code, dispense is 0 and the credit is unchanged.
- R8: Return and dispense respond to the coin in the same cycle it is presented, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_i | input | 2 | Coin presented this cycle (00 none, 01 5c, 10 10c, 11 25c) |
| ret_o | output | 2 | Coin code handed back this cycle (change or refused coin) |
| prod_o | output | 1 | Dispense one product this cycle |
| credit_o | output | 3 | Held credit in 5-cent units |

## Verification
The assertions assume that the coin input always carries a known 2-bit value on every clock edge. They also assume that reset is held for at least one rising edge before normal operation starts. The bench meets both assumptions: it drives the coin code only at falling edges and sets it to 00 whenever reset is asserted, so no undefined code reaches the decision logic. The bench reaches every credit value by adding nickels after a reset and then applies every coin code from that value. A long pseudo-random coin stream then covers chained sales, refusals and idle cycles.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [1:0] {
        COIN_NONE    = 2'b00,
        COIN_NICKEL  = 2'b01,
        COIN_DIME    = 2'b10,
        COIN_QUARTER = 2'b11
    } coin_e;

    // Coin values expressed in 5-cent units
    localparam int NICKEL_UNITS  = 1;
    localparam int DIME_UNITS    = 2;
    localparam int QUARTER_UNITS = 5;

endpackage

// File: rtl/vend_coin_value.sv
module vend_coin_value
    import vend_pkg::*;
#(
    parameter int SUM_W = 5
) (
    input  coin_e             coin,
    output logic [SUM_W-1:0]  units
);

    always_comb begin
        unique case (coin)
            COIN_NICKEL:  units = SUM_W'(NICKEL_UNITS);
            COIN_DIME:    units = SUM_W'(DIME_UNITS);
            COIN_QUARTER: units = SUM_W'(QUARTER_UNITS);
            default:      units = '0;
        endcase
    end

endmodule

// File: rtl/vend_decide.sv
module vend_decide
    import vend_pkg::*;
#(
    parameter int CREDIT_W = 3,
    parameter int SUM_W    = 5,
    parameter int PRICE_U  = 8,
    parameter int CEIL_U   = 10
) (
    input  logic [CREDIT_W-1:0] credit,
    input  logic [SUM_W-1:0]    units,
    input  coin_e               coin,
    output logic [CREDIT_W-1:0] credit_nx,
    output coin_e               ret,
    output logic                prod
);

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] change;

    always_comb begin
        total     = SUM_W'(credit) + units;
        change    = total - SUM_W'(PRICE_U);
        credit_nx = credit;
        ret       = COIN_NONE;
        prod      = 1'b0;
        if (total > SUM_W'(CEIL_U)) begin
            // Over the ceiling: hand the coin back, keep the credit
            ret = coin;
        end else if (total >= SUM_W'(PRICE_U)) begin
            prod      = 1'b1;
            credit_nx = '0;
            if (change == SUM_W'(NICKEL_UNITS)) begin
                ret = COIN_NICKEL;
            end else if (change == SUM_W'(DIME_UNITS)) begin
                ret = COIN_DIME;
            end
        end else begin
            credit_nx = total[CREDIT_W-1:0];
        end
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int CREDIT_W = 3,
    parameter int PRICE_U  = 8,
    parameter int CEIL_U   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          coin_i,
    output logic [1:0]          ret_o,
    output logic                prod_o,
    output logic [CREDIT_W-1:0] credit_o
);

    localparam int SUM_W = CREDIT_W + 2;

    typedef struct packed {
        logic [CREDIT_W-1:0] credit;
    } state_t;

    state_t              st_d, st_q;
    coin_e               coin;
    coin_e               ret;
    logic [SUM_W-1:0]    units;
    logic [CREDIT_W-1:0] credit_nx;

    assign coin = coin_e'(coin_i);

    vend_coin_value #(.SUM_W(SUM_W)) u_value (
        .coin  (coin),
        .units (units)
    );

    vend_decide #(
        .CREDIT_W (CREDIT_W),
        .SUM_W    (SUM_W),
        .PRICE_U  (PRICE_U),
        .CEIL_U   (CEIL_U)
    ) u_decide (
        .credit    (st_q.credit),
        .units     (units),
        .coin      (coin),
        .credit_nx (credit_nx),
        .ret       (ret),
        .prod      (prod_o)
    );

    always_comb begin
        st_d        = st_q;
        st_d.credit = credit_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ret_o    = ret;
    assign credit_o = st_q.credit;

    // R1: the first cycle after reset starts from zero credit
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> credit_o == '0);

    // R2: an idle cycle produces nothing and holds the credit
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        coin_i == 2'b00 |-> (ret_o == 2'b00 && !prod_o));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        coin_i == 2'b00 |=> $stable(credit_o));

    // R4: a kept coin with no sale raises the credit
    p_accumulate_r4: assert property (@(posedge clk) disable iff (rst)
        (coin_i != 2'b00 && !prod_o && ret_o == 2'b00) |=> credit_o > $past(credit_o));

    // R5: a sale empties the credit
    p_sale_clears_r5: assert property (@(posedge clk) disable iff (rst)
        prod_o |=> credit_o == '0);

    // R6: change is never a quarter and never the coin just inserted
    p_change_small_r6: assert property (@(posedge clk) disable iff (rst)
        prod_o |-> (ret_o != 2'b11 && ret_o != coin_i));

    // R7: a refused coin is echoed and the credit stays put
    p_refuse_echo_r7: assert property (@(posedge clk) disable iff (rst)
        (!prod_o && ret_o != 2'b00) |-> ret_o == coin_i);
    p_refuse_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!prod_o && ret_o != 2'b00) |=> $stable(credit_o));

endmodule

// File: tb/vend_ctrl_test.sv
`timescale 1ns/1ps
module vend_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] coin_i = 2'b00;
    logic [1:0] ret_o;
    logic       prod_o;
    logic [2:0] credit_o;

    int checks = 0;
    int errors = 0;
    int model_credit = 0;   // cents held by the reference
    string last_tag = "R1";

    always #2 clk = ~clk;   // 250 MHz

    vend_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .coin_i   (coin_i),
        .ret_o    (ret_o),
        .prod_o   (prod_o),
        .credit_o (credit_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // R3: coin values in cents
    function automatic int cents(input logic [1:0] c);
        case (c)
            2'b01:   return 5;
            2'b10:   return 10;
            2'b11:   return 25;
            default: return 0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        coin_i = 2'b00;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_credit = 0;
        #1;
        check(credit_o == 3'd0, "R1", "credit after reset", credit_o, 0);
        last_tag = "R1";
    endtask

    task automatic step(input logic [1:0] c);
        int total, exp_ret, exp_prod, next_credit;
        string tag;
        @(negedge clk);
        coin_i = c;
        #1;
        // credit reflects what the previous step left behind
        check(credit_o == 3'(model_credit / 5), last_tag, "held credit",
              credit_o, model_credit / 5);
        total = model_credit + cents(c);
        if (c == 2'b00) begin
            tag = "R2";
            exp_ret = 0; exp_prod = 0; next_credit = model_credit;
        end else if (total > 50) begin
            tag = "R7";
            exp_ret = c; exp_prod = 0; next_credit = model_credit;
        end else if (total >= 40) begin
            tag = (total > 40) ? "R6" : "R5";
            exp_ret = (total - 40) / 5; exp_prod = 1; next_credit = 0;
        end else begin
            tag = "R4";
            exp_ret = 0; exp_prod = 0; next_credit = total;
        end
        // R8: outputs checked in the same cycle the coin is driven; R3 value table
        check(ret_o == 2'(exp_ret), {tag, " R8 R3"}, "return code", ret_o, exp_ret);
        check(prod_o == 1'(exp_prod), {tag, " R8"}, "dispense", prod_o, exp_prod);
        @(posedge clk);
        model_credit = next_credit;
        last_tag = tag;
    endtask

    initial begin
        logic [7:0] lfsr;
        do_reset();
        // Every credit value against every coin code
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 4; c++) begin
                do_reset();
                for (int k = 0; k < s; k++) step(2'b01);
                step(2'(c));
                step(2'b00);
            end
        end
        // Reset in the middle of a build-up clears the credit
        do_reset();
        step(2'b11);
        step(2'b10);
        do_reset();
        step(2'b00);
        // Pseudo-random stream
        lfsr = 8'hA5;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[1:0]);
        end
        step(2'b00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule